// File: doc/BRIEF.md
# Multimode Converter Serial Command Port

This block is the device-side digital controller for a multichannel 16-bit converter reached over a four-wire serial port: active-low select, serial clock, serial data in, serial data out, plus a strobe line. The host sends 8-bit command bytes, MSB first. Each byte is sorted into one of three classes by its low nibble: conversion-start, per-channel input configuration, or mode-control. The block keeps a configuration for each channel and one operating mode.

The block frames every conversion. It drives a track/hold control, asks the converter for a sample through a start/done handshake, and shifts the 16-bit result out on the data line. The operating mode sets how long the frame is, where the result sits in it and when hold begins. In the internal-clock mode the conversion time comes from a fixed count of system clock cycles, and the strobe marks when the result is ready. The power-down modes only raise flags and block conversions. The serial inputs are sampled by the system clock through two-stage synchronizers, so the serial clock must run well below the system clock.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset the mode is external clock (code 000), every channel holds single-ended with range code 001, and `doutEn`, `holdCtl`, `sstrb`, `pdPartial` and `pdFull` are all 0.
- R2: A byte is classified by bits [3:0]. 0000 is conversion-start `1 c2 c1 c0 0000`. 1000 is mode-control `1 m2 m1 m0 1000`. Any other value is configuration `1 c2 c1 c0 d r2 r1 r0`, where c selects the channel, d=1 means differential and r is the range code.
- R3: While select is low and no byte is in progress, serial-clock rising edges with a 0 data bit are ignored. A byte begins only at a 1 bit.
- R4: In external-clock mode a conversion-start frame spans 32 rising edges. After edge 16+j (j=0..15) `dout` carries result bit 15-j. `doutEn` is 1 only after edges 16 to 31. `selChan` shows the commanded channel.
- R5: In external-clock and internal-clock modes `holdCtl` is 0 after edge 7 and 1 after edge 8. It returns to 0 when the frame ends.
- R6: `sstrb` is 1 only while `dout` is presenting result bit 15. It drops at the next rising edge.
- R7: A configuration byte stores d and r for its channel only. They appear on `selDiff`/`selRange` when that channel is next converted.
- R8: Mode codes are 000 external clock, 001 external acquisition, 010 internal clock, 100 reset, 110 partial power-down and 111 full power-down. Codes 011 and 101 leave the mode unchanged.
- R9: Mode code 100 restores every channel to its reset configuration and sets the mode to external clock.
- R10: In external-acquisition mode `holdCtl` rises after edge 16, not after edge 8. Result bit 15-j follows edge 24+j, and the frame spans 40 edges.
- R11: In internal-clock mode the result is taken `INT_CYCLES` system clocks after the command byte ends. `sstrb` then rises with bit 15 on `dout`. Bit 15-j follows edge 8+j for j=1..15, and the frame spans 24 edges.
- R12: Mode 110 sets `pdPartial` and mode 111 sets `pdFull`. In either mode a conversion-start byte raises neither `holdCtl` nor `doutEn`.
- R13: Raising select at any point clears `doutEn` and `holdCtl` and discards any partial byte. The next byte is decoded from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial command data, MSB first |
| dout | output | 1 | Serial result data (0 when not driven) |
| doutEn | output | 1 | Output drive enable; pad is high impedance when 0 |
| sstrb | output | 1 | Strobe marking result MSB on `dout` |
| holdCtl | output | 1 | Track/hold control, 1 = hold |
| convStart | output | 1 | One-cycle request to the converter |
| convDone | input | 1 | Converter result-valid pulse |
| sampleData | input | 16 | Converter result code, 0xFFFF full scale |
| selChan | output | 3 | Channel of the current conversion |
| selDiff | output | 1 | Differential flag of that channel |
| selRange | output | 3 | Range code of that channel |
| pdPartial | output | 1 | Partial power-down flag |
| pdFull | output | 1 | Full power-down flag |

## Verification
External-clock frames run through a table of channels and result codes. The codes include all-ones full scale, all zeros, alternating bits and values near mid-scale, so a bit slip, a reversed order or a stuck bit gives a wrong word. The same conversion byte is then sent in each mode, which separates the frame lengths, hold points and strobe timing of the three conversion modes. Configuration writes, reserved mode codes, the reset code, leading idle zeros and select dropped mid-byte or mid-frame are each followed by a conversion on the affected channel. That conversion shows whether the stored state changed.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  localparam int CMD_W = 8;
  localparam int CH_W  = 3;
  localparam int RNG_W = 3;
  localparam logic [RNG_W-1:0] DEF_RANGE = 3'b001;

  typedef enum logic [2:0] {
    MODE_EXTCLK = 3'b000,
    MODE_EXTACQ = 3'b001,
    MODE_INTCLK = 3'b010,
    MODE_RST    = 3'b100,
    MODE_PPD    = 3'b110,
    MODE_FPD    = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    CMD_CONV,
    CMD_CFG,
    CMD_MODE
  } cmd_e;

  typedef struct packed {
    logic shiftIn;
    logic applyCmd;
    logic acceptConv;
    logic loadExt;
    logic loadInt;
    logic shiftOut;
  } ctl_strobe_t;

  function automatic cmd_e classify(input logic [3:0] lowNib);
    case (lowNib)
      4'b0000: classify = CMD_CONV;
      4'b1000: classify = CMD_MODE;
      default: classify = CMD_CFG;
    endcase
  endfunction

endpackage

// File: rtl/adc_cmd_ctl.sv
module adc_cmd_ctl
  import adc_cmd_pkg::*;
#(
  parameter int RES_W      = 16,
  parameter int INT_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csActive,
  input  logic        sclkRise,
  input  logic        dinBit,
  input  cmd_e        byteClass,
  input  mode_e       curMode,
  output ctl_strobe_t strobe,
  output logic        holdCtl,
  output logic        doutEn,
  output logic        sstrb,
  output logic        convStart
);

  localparam int EXT_MSB  = 2 * CMD_W;
  localparam int ACQ_HOLD = 2 * CMD_W;
  localparam int ACQ_MSB  = 3 * CMD_W;
  localparam int INT_MSB  = CMD_W;
  localparam int CNT_W    = $clog2(ACQ_MSB + RES_W + 1);
  localparam int IC_W     = $clog2(INT_CYCLES + 1);

  typedef enum logic [1:0] {S_WAIT, S_CMD, S_CONV} st_e;

  st_e              state;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] newCnt;
  logic [CNT_W-1:0] msbAt;
  logic [CNT_W-1:0] lenAt;
  logic [IC_W-1:0]  intCnt;
  logic             intBusy;
  logic             isExt;
  logic             convOk;
  logic             byteEnd;

  always_comb begin
    case (curMode)
      MODE_EXTACQ: msbAt = CNT_W'(ACQ_MSB);
      MODE_INTCLK: msbAt = CNT_W'(INT_MSB);
      default:     msbAt = CNT_W'(EXT_MSB);
    endcase
    lenAt   = msbAt + CNT_W'(RES_W);
    isExt   = (curMode != MODE_INTCLK);
    convOk  = (curMode == MODE_EXTCLK) || (curMode == MODE_EXTACQ) ||
              (curMode == MODE_INTCLK);
    newCnt  = edgeCnt + 1'b1;
    byteEnd = (state == S_CMD) && sclkRise && (edgeCnt == CNT_W'(CMD_W - 1));
  end

  always_comb begin
    strobe = '0;
    if (csActive) begin
      case (state)
        S_WAIT: strobe.shiftIn = sclkRise && dinBit;
        S_CMD: begin
          strobe.shiftIn = sclkRise;
          if (byteEnd) begin
            if (byteClass == CMD_CONV) strobe.acceptConv = convOk;
            else                       strobe.applyCmd   = 1'b1;
          end
        end
        default: begin
          strobe.loadInt = intBusy && (intCnt == '0);
          if (sclkRise && !intBusy) begin
            strobe.loadExt  = isExt && (newCnt == msbAt);
            strobe.shiftOut = (newCnt > msbAt) && (newCnt < lenAt);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_WAIT;
      edgeCnt   <= '0;
      intCnt    <= '0;
      intBusy   <= 1'b0;
      holdCtl   <= 1'b0;
      doutEn    <= 1'b0;
      sstrb     <= 1'b0;
      convStart <= 1'b0;
    end else if (!csActive) begin
      state     <= S_WAIT;
      edgeCnt   <= '0;
      intBusy   <= 1'b0;
      holdCtl   <= 1'b0;
      doutEn    <= 1'b0;
      sstrb     <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= 1'b0;
      case (state)
        S_WAIT: begin
          if (sclkRise && dinBit) begin
            state   <= S_CMD;
            edgeCnt <= CNT_W'(1);
          end
        end
        S_CMD: begin
          if (sclkRise) edgeCnt <= newCnt;
          if (byteEnd) begin
            if (strobe.acceptConv) begin
              state <= S_CONV;
              if (curMode != MODE_EXTACQ) begin
                holdCtl   <= 1'b1;
                convStart <= 1'b1;
              end
              if (curMode == MODE_INTCLK) begin
                intBusy <= 1'b1;
                intCnt  <= IC_W'(INT_CYCLES - 1);
              end
            end else begin
              state   <= S_WAIT;
              edgeCnt <= '0;
            end
          end
        end
        default: begin
          if (intBusy) begin
            if (intCnt == '0) begin
              intBusy <= 1'b0;
              doutEn  <= 1'b1;
              sstrb   <= 1'b1;
            end else begin
              intCnt <= intCnt - 1'b1;
            end
          end else if (sclkRise) begin
            edgeCnt <= newCnt;
            sstrb   <= 1'b0;
            if ((curMode == MODE_EXTACQ) && (newCnt == CNT_W'(ACQ_HOLD))) begin
              holdCtl   <= 1'b1;
              convStart <= 1'b1;
            end
            if (isExt && (newCnt == msbAt)) begin
              doutEn <= 1'b1;
              sstrb  <= 1'b1;
            end
            if (newCnt == lenAt) begin
              state   <= S_WAIT;
              edgeCnt <= '0;
              doutEn  <= 1'b0;
              holdCtl <= 1'b0;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_cmd_dp.sv
module adc_cmd_dp
  import adc_cmd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinBit,
  input  ctl_strobe_t       strobe,
  input  logic              convDone,
  input  logic [RES_W-1:0]  sampleData,
  output cmd_e              byteClass,
  output mode_e             curMode,
  output logic              doutBit,
  output logic [CH_W-1:0]   selChan,
  output logic              selDiff,
  output logic [RNG_W-1:0]  selRange,
  output logic              pdPartial,
  output logic              pdFull
);

  logic [CMD_W-2:0] cmdSh;
  logic [CMD_W-1:0] nextByte;
  logic [CH_W-1:0]  byteChan;
  logic [2:0]       modeCode;
  logic             cfgWrite;
  logic             rstCmd;
  logic [RES_W-1:0] resReg;
  logic [RES_W-1:0] outSh;
  logic             diffArr  [NUM_CH];
  logic [RNG_W-1:0] rangeArr [NUM_CH];

  assign nextByte  = {cmdSh, dinBit};
  assign byteClass = classify(nextByte[3:0]);
  assign byteChan  = nextByte[6:4];
  assign modeCode  = nextByte[6:4];
  assign cfgWrite  = strobe.applyCmd && (byteClass == CMD_CFG);
  assign rstCmd    = strobe.applyCmd && (byteClass == CMD_MODE) &&
                     (modeCode == MODE_RST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cmdSh <= '0;
    else if (strobe.shiftIn) cmdSh <= {cmdSh[CMD_W-3:0], dinBit};
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic             diffQ;
    logic [RNG_W-1:0] rangeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN || 1'b0) begin
        diffQ  <= 1'b0;
        rangeQ <= DEF_RANGE;
      end else if (rstCmd) begin
        diffQ  <= 1'b0;
        rangeQ <= DEF_RANGE;
      end else if (cfgWrite && (byteChan == CH_W'(g))) begin
        diffQ  <= nextByte[3];
        rangeQ <= nextByte[2:0];
      end
    end
    assign diffArr[g]  = diffQ;
    assign rangeArr[g] = rangeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_EXTCLK;
    end else if (strobe.applyCmd && (byteClass == CMD_MODE)) begin
      case (modeCode)
        3'b100:         curMode <= MODE_EXTCLK;
        3'b011, 3'b101: curMode <= curMode;
        default:        curMode <= mode_e'(modeCode);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selChan  <= '0;
      selDiff  <= 1'b0;
      selRange <= '0;
    end else if (strobe.acceptConv) begin
      selChan  <= byteChan;
      selDiff  <= diffArr[byteChan];
      selRange <= rangeArr[byteChan];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         resReg <= '0;
    else if (convDone) resReg <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outSh <= '0;
    else if (strobe.loadInt)  outSh <= sampleData;
    else if (strobe.loadExt)  outSh <= resReg;
    else if (strobe.shiftOut) outSh <= {outSh[RES_W-2:0], 1'b0};
  end

  assign doutBit   = outSh[RES_W-1];
  assign pdPartial = (curMode == MODE_PPD);
  assign pdFull    = (curMode == MODE_FPD);

endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import adc_cmd_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES_W      = 16,
  parameter int INT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              doutEn,
  output logic              sstrb,
  output logic              holdCtl,
  output logic              convStart,
  input  logic              convDone,
  input  logic [RES_W-1:0]  sampleData,
  output logic [CH_W-1:0]   selChan,
  output logic              selDiff,
  output logic [RNG_W-1:0]  selRange,
  output logic              pdPartial,
  output logic              pdFull
);

  logic [1:0]  csS;
  logic [1:0]  sclkS;
  logic [1:0]  dinS;
  logic        sclkQ;
  logic        csActive;
  logic        sclkRise;
  logic        doutBit;
  ctl_strobe_t strobe;
  cmd_e        byteClass;
  mode_e       curMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS   <= 2'b11;
      sclkS <= 2'b00;
      dinS  <= 2'b00;
      sclkQ <= 1'b0;
    end else begin
      csS   <= {csS[0], csN};
      sclkS <= {sclkS[0], sclk};
      dinS  <= {dinS[0], din};
      sclkQ <= sclkS[1];
    end
  end

  assign csActive = ~csS[1];
  assign sclkRise = sclkS[1] & ~sclkQ;

  adc_cmd_ctl #(
    .RES_W(RES_W),
    .INT_CYCLES(INT_CYCLES)
  ) ctl_i (
    .clk(clk),
    .rstN(rstN),
    .csActive(csActive),
    .sclkRise(sclkRise),
    .dinBit(dinS[1]),
    .byteClass(byteClass),
    .curMode(curMode),
    .strobe(strobe),
    .holdCtl(holdCtl),
    .doutEn(doutEn),
    .sstrb(sstrb),
    .convStart(convStart)
  );

  adc_cmd_dp #(
    .NUM_CH(NUM_CH),
    .RES_W(RES_W)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .dinBit(dinS[1]),
    .strobe(strobe),
    .convDone(convDone),
    .sampleData(sampleData),
    .byteClass(byteClass),
    .curMode(curMode),
    .doutBit(doutBit),
    .selChan(selChan),
    .selDiff(selDiff),
    .selRange(selRange),
    .pdPartial(pdPartial),
    .pdFull(pdFull)
  );

  assign dout = doutEn & doutBit;

endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csActive,
  input logic       doutEn,
  input logic       holdCtl,
  input logic       sstrb,
  input logic       convStart,
  input logic       pdPartial,
  input logic       pdFull,
  input logic [2:0] modeBits
);

  AST_CS_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (!doutEn && !holdCtl)); // R13

  AST_STROBE_ONLY_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    sstrb |-> doutEn); // R6

  AST_DRIVE_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |-> holdCtl); // R5

  AST_CONVSTART_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R5

  AST_PWRDN_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pdPartial || pdFull) |-> !holdCtl); // R12

  AST_MODE_NEVER_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits != 3'b011) && (modeBits != 3'b101) && (modeBits != 3'b100)); // R8

endmodule

bind adc_cmd_port adc_cmd_port_chk chk_i (
  .clk(clk),
  .rstN(rstN),
  .csActive(csActive),
  .doutEn(doutEn),
  .holdCtl(holdCtl),
  .sstrb(sstrb),
  .convStart(convStart),
  .pdPartial(pdPartial),
  .pdFull(pdFull),
  .modeBits(curMode)
);

// File: tb/adc_cmd_port_tb_top.sv
module adc_cmd_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        dout, doutEn, sstrb, holdCtl, convStart, convDone;
  logic [15:0] sampleData = 16'h0;
  logic [2:0]  selChan, selRange;
  logic        selDiff, pdPartial, pdFull;
  logic [3:0]  donePipe = 4'h0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic oeL [0:47];
  logic dL  [0:47];
  logic stL [0:47];
  logic hdL [0:47];

  localparam logic [23:0] VEC [0:5] = '{
    24'h80_A5C3, 24'hF0_FFFF, 24'hA0_0000,
    24'hC0_8001, 24'h90_7FFE, 24'hE0_1234
  };

  always #4 clk = ~clk;

  adc_cmd_port dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .doutEn(doutEn), .sstrb(sstrb), .holdCtl(holdCtl),
    .convStart(convStart), .convDone(convDone), .sampleData(sampleData),
    .selChan(selChan), .selDiff(selDiff), .selRange(selRange),
    .pdPartial(pdPartial), .pdFull(pdFull)
  );

  always @(posedge clk) donePipe <= {donePipe[2:0], convStart};
  assign convDone = donePipe[3];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int idx);
    din = b;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    if (idx >= 0) begin
      oeL[idx] = doutEn; dL[idx] = dout; stL[idx] = sstrb; hdL[idx] = holdCtl;
    end
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [7:0] cmd, input int nEdges, input int lead,
                       input bit intWait, input bit keepCs);
    for (int i = 0; i < 48; i++) begin
      oeL[i] = 1'b0; dL[i] = 1'b0; stL[i] = 1'b0; hdL[i] = 1'b0;
    end
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < lead; i++) sendBit(1'b0, -1);
    for (int k = 1; k <= nEdges; k++) begin
      if (intWait && k == 9) begin
        for (int t = 0; t < 500 && !sstrb; t++) @(negedge clk);
        oeL[8] = doutEn; dL[8] = dout; stL[8] = sstrb;
      end
      sendBit((k <= 8) ? cmd[8-k] : 1'b0, k);
    end
    if (!keepCs) begin
      csN = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  function automatic logic [15:0] wordAt(input int base);
    logic [15:0] w;
    for (int j = 0; j < 16; j++) w[15-j] = dL[base+j];
    return w;
  endfunction

  task automatic sendCmd(input logic [7:0] cmd);
    frame(cmd, 8, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(doutEn == 0 && holdCtl == 0 && sstrb == 0, "R1 idle outputs",
        {doutEn, holdCtl, sstrb}, 0);
    chk(pdPartial == 0 && pdFull == 0, "R1 power flags", {pdPartial, pdFull}, 0);

    // R4/R5/R6 table walk in external-clock mode
    for (int v = 0; v < 6; v++) begin
      sampleData = VEC[v][15:0];
      frame(VEC[v][23:16], 32, 0, 1'b0, 1'b0);
      chk(wordAt(16) == VEC[v][15:0], "R4 result word", wordAt(16), VEC[v][15:0]);
      chk(selChan == VEC[v][22:20], "R4 channel", selChan, VEC[v][22:20]);
      chk(oeL[15] == 0 && oeL[16] == 1 && oeL[31] == 1, "R4 drive window",
          {oeL[15], oeL[16], oeL[31]}, 3'b011);
      chk(hdL[7] == 0 && hdL[8] == 1 && hdL[31] == 1, "R5 hold point",
          {hdL[7], hdL[8], hdL[31]}, 3'b011);
      chk(stL[16] == 1 && stL[15] == 0 && stL[17] == 0, "R6 strobe",
          {stL[15], stL[16], stL[17]}, 3'b010);
    end
    chk(doutEn == 0 && holdCtl == 0, "R4 frame end", {doutEn, holdCtl}, 0);

    // R1/R7 default configuration, then per-channel writes (R2 classification)
    sampleData = 16'h0F0F;
    frame(8'hB0, 32, 0, 1'b0, 1'b0);
    chk(selDiff == 0 && selRange == 3'b001, "R1 default config", {selDiff, selRange}, 4'h1);
    sendCmd(8'hB2);
    sendCmd(8'hDE);
    frame(8'hB0, 32, 0, 1'b0, 1'b0);
    chk(selDiff == 0 && selRange == 3'b010, "R7 ch3 config", {selDiff, selRange}, 4'h2);
    frame(8'hD0, 32, 0, 1'b0, 1'b0);
    chk(selDiff == 1 && selRange == 3'b110, "R2 R7 ch5 config", {selDiff, selRange}, 4'hE);
    frame(8'h80, 32, 0, 1'b0, 1'b0);
    chk(selDiff == 0 && selRange == 3'b001, "R7 other channel untouched",
        {selDiff, selRange}, 4'h1);

    // R3 leading zero bits
    sampleData = 16'h5A3C;
    frame(8'hE0, 32, 3, 1'b0, 1'b0);
    chk(wordAt(16) == 16'h5A3C && selChan == 3'd6, "R3 leading zeros",
        wordAt(16), 16'h5A3C);

    // R10 external acquisition
    sendCmd(8'h98);
    sampleData = 16'hC3A5;
    frame(8'hB0, 40, 0, 1'b0, 1'b0);
    chk(hdL[8] == 0 && hdL[15] == 0 && hdL[16] == 1, "R10 hold point",
        {hdL[8], hdL[15], hdL[16]}, 3'b001);
    chk(wordAt(24) == 16'hC3A5, "R10 result word", wordAt(24), 16'hC3A5);
    chk(oeL[23] == 0 && stL[24] == 1 && oeL[39] == 1, "R10 window",
        {oeL[23], stL[24], oeL[39]}, 3'b011);

    // R11 internal clock
    sendCmd(8'hA8);
    sampleData = 16'h9D61;
    frame(8'h90, 24, 0, 1'b1, 1'b0);
    chk(stL[8] == 1 && oeL[8] == 1, "R11 strobe at completion", {stL[8], oeL[8]}, 2'b11);
    chk(wordAt(8) == 16'h9D61, "R11 result word", wordAt(8), 16'h9D61);
    chk(hdL[8] == 1 && stL[9] == 0 && doutEn == 0, "R11 R5 hold and end",
        {hdL[8], stL[9], doutEn}, 3'b100);

    // R8 reserved codes keep internal-clock mode
    sendCmd(8'hB8);
    sendCmd(8'hD8);
    sampleData = 16'h0001;
    frame(8'h90, 24, 0, 1'b1, 1'b0);
    chk(stL[8] == 1 && wordAt(8) == 16'h0001, "R8 reserved code ignored",
        wordAt(8), 16'h0001);

    // R12 power-down
    sendCmd(8'hF8);
    chk(pdFull == 1 && pdPartial == 0, "R12 full flag", {pdFull, pdPartial}, 2'b10);
    frame(8'hB0, 32, 0, 1'b0, 1'b0);
    begin
      logic anyAct = 1'b0;
      for (int k = 1; k <= 32; k++) anyAct |= oeL[k] | hdL[k];
      chk(!anyAct, "R12 conversion blocked", anyAct, 0);
    end
    sendCmd(8'hE8);
    chk(pdFull == 0 && pdPartial == 1, "R12 partial flag", {pdFull, pdPartial}, 2'b01);

    // R9 reset code
    sendCmd(8'hC8);
    chk(pdFull == 0 && pdPartial == 0, "R9 flags cleared", {pdFull, pdPartial}, 0);
    sampleData = 16'hBEEF;
    frame(8'hD0, 32, 0, 1'b0, 1'b0);
    chk(selDiff == 0 && selRange == 3'b001, "R9 config restored", {selDiff, selRange}, 4'h1);
    chk(wordAt(16) == 16'hBEEF && oeL[16] == 1, "R9 external clock mode",
        wordAt(16), 16'hBEEF);

    // R13 abort mid-byte and mid-frame
    frame(8'h92, 5, 0, 1'b0, 1'b0);
    sampleData = 16'h4321;
    frame(8'h90, 32, 0, 1'b0, 1'b0);
    chk(selRange == 3'b001 && wordAt(16) == 16'h4321, "R13 partial byte dropped",
        selRange, 3'b001);
    frame(8'hB0, 20, 0, 1'b0, 1'b1);
    chk(oeL[20] == 1, "R13 mid-frame drive", oeL[20], 1);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    chk(doutEn == 0 && holdCtl == 0, "R13 abort clears", {doutEn, holdCtl}, 0);
    sampleData = 16'hA001;
    frame(8'hF0, 32, 0, 1'b0, 1'b0);
    chk(wordAt(16) == 16'hA001 && selChan == 3'd7, "R13 fresh frame",
        wordAt(16), 16'hA001);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule